// File: doc/BRIEF.md
# Pulse-Per-Second Phase Error Capture

This block measures how a local oscillator drifts against a once-per-second reference pulse. The oscillator drives the block's clock. A prescaler makes a count enable once every four clocks. An 8-bit counter advances on that enable through a span of 250 values. It runs from a reload value of 6 up to 255, then starts again at 6. A wrap tick marks every reload.

The reference pulse arrives with no timing relation to the clock. It passes through a two-flop synchronizer and a rising-edge detector. On each detected edge the current count is latched and a one-cycle strobe is raised. The counter is never cleared by a capture, so the latched value is a running phase error. If the oscillator runs at an exact multiple of 1 kHz, the value repeats from one second to the next. If the oscillator is fast the value climbs each second, and if it is slow the value falls. One step of change equals four oscillator cycles of accumulated phase.

Top module: `pps_phase_capture`

## Requirements
- R1: The counter advances by exactly one every 4 clocks. After reset is released, the first advance takes effect on the 4th rising clock edge.
- R2: The counter only takes the values 6 to 255. An advance from 255 loads 6, so the count repeats every 250 advances (1000 clocks).
- R3: `wrap_tick_o` is a one-cycle pulse. It is high in exactly the cycle in which the counter has just been reloaded with 6, which happens once every 1000 clocks.
- R4: Suppose the reference is first sampled high at clock edge m, after being sampled low at edge m-1. Then `cap_stb_o` is high after edge m+2, and `cap_val_o` then shows the count as it stood after edge m+1.
- R5: Each rising edge of the reference gives exactly one capture and a single-cycle strobe, however long the reference stays high (1 cycle or more).
- R6: `cap_val_o` holds its value between captures.
- R7: A capture does not disturb the counter, which keeps running through the sample.
- R8: The captured value changes each second by the reference period in clocks, divided by 4, modulo 250. A period of 1000 clocks gives the same value every time. A period of 1004 clocks (fast oscillator) raises it by 1 each time. A period of 996 clocks (slow oscillator) lowers it by 1 each time.
- R9: While reset is asserted (`rst_n` low), the counter holds 6, the prescaler phase is cleared, `cap_val_o` is 0, and `cap_stb_o` and `wrap_tick_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pps_i | input | 1 | Asynchronous once-per-second reference pulse |
| cap_val_o | output | 8 | Count latched at the last reference edge |
| cap_stb_o | output | 1 | One-cycle strobe marking a new capture |
| wrap_tick_o | output | 1 | One-cycle pulse on each counter reload |

## Verification
The bench builds the block with its default parameters: divide by 4, an 8-bit counter and a reload value of 6. This gives a wrap every 1000 clocks, so a scaled "second" of about 1000 clocks brings many wraps and captures within a short run. Reference periods of 1000, 1004, 996 and 1400 clocks give a steady sample, a climbing sample, a falling sample and a sample that jumps across the 255-to-6 wrap. Pulse widths of 1, 3 and 20 cycles test that each edge gives a single capture.

// File: rtl/pps_cap_pkg.sv
package pps_cap_pkg;

    // State of the reference-pulse synchronizer and edge detector
    typedef struct packed {
        logic meta;   // first synchronizer stage
        logic sync;   // second synchronizer stage
        logic last;   // delayed copy for edge detection
    } ref_sync_t;

endpackage

// File: rtl/pps_div_enable.sv
module pps_div_enable #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.ph == PH_LAST) st_d.ph = '0;
        else                    st_d.ph = st_q.ph + PH_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = (st_q.ph == PH_LAST);

    // R1: enable never lasts two consecutive cycles
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R1: phase stays in range
    p_phase_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ph <= PH_LAST);
endmodule

// File: rtl/pps_wrap_counter.sv
module pps_wrap_counter #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned RELOAD = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_TOP  = '1;
    localparam logic [CNT_W-1:0] CNT_BASE = CNT_W'(RELOAD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wrap;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        if (adv_i) begin
            if (st_q.cnt == CNT_TOP) begin
                st_d.cnt  = CNT_BASE;
                st_d.wrap = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= CNT_BASE;
            st_q.wrap <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = st_q.wrap;

    // R2: count never drops below the reload value
    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt >= CNT_BASE);

    // R1: an enable below the top steps the count by one
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && st_q.cnt != CNT_TOP) |=> st_q.cnt == $past(st_q.cnt) + CNT_W'(1));

    // R1: without an enable the count holds
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(st_q.cnt));

    // R3: the wrap tick coincides with a freshly reloaded count
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> (st_q.cnt == CNT_BASE));
endmodule

// File: rtl/pps_ref_edge.sv
module pps_ref_edge
    import pps_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    ref_sync_t st_d, st_q;

    always_comb begin
        st_d.meta = ref_i;
        st_d.sync = st_q.meta;
        st_d.last = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.sync & ~st_q.last;

    // R5: one detection per rising edge
    p_single_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pps_phase_capture.sv
module pps_phase_capture #(
    parameter int unsigned DIV    = 4,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned RELOAD = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pps_i,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             cap_stb_o,
    output logic             wrap_tick_o
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             stb;
    } cap_state_t;

    logic             adv;
    logic             rise;
    logic [CNT_W-1:0] cnt;
    cap_state_t       st_d, st_q;

    pps_div_enable #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (adv)
    );

    pps_wrap_counter #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (adv),
        .cnt_o  (cnt),
        .wrap_o (wrap_tick_o)
    );

    pps_ref_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (ref_pps_i),
        .rise_o (rise)
    );

    always_comb begin
        st_d     = st_q;
        st_d.stb = rise;
        if (rise) st_d.val = cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_val_o = st_q.val;
    assign cap_stb_o = st_q.stb;

    // R6: latched value holds while no edge is seen
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(st_q.val));

    // R5: strobe lasts a single cycle
    p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb_o |=> !cap_stb_o);

    // R7: capturing does not stall the counter
    p_run_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && adv && cnt != '1) |=> cnt == $past(cnt) + CNT_W'(1));
endmodule

// File: tb/pps_phase_capture_tb.sv
module pps_phase_capture_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SPAN       = 250;
    localparam int BASE       = 6;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_pps = 1'b0;
    logic [7:0] cap_val;
    logic       cap_stb;
    logic       wrap_tick;

    int errors = 0;
    int checks = 0;
    int n = 0;          // rising edges since reset release
    int cycles = 0;
    bit hist[$];        // reference value sampled at each edge
    int caps[$];
    bit done = 0;

    pps_phase_capture u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_pps_i   (ref_pps),
        .cap_val_o   (cap_val),
        .cap_stb_o   (cap_stb),
        .wrap_tick_o (wrap_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit ref_at(int k);
        if (k < 1 || k > hist.size()) return 1'b0;
        return hist[k-1];
    endfunction

    function automatic int count_after(int k);
        return BASE + ((k / 4) % SPAN);
    endfunction

    function automatic int wrap_diff(int a, int b);
        int d;
        d = (((b - a) % SPAN) + SPAN) % SPAN;
        if (d > SPAN/2) d = d - SPAN;
        return d;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", req, act, exp, n);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst_n) begin
            n++;
            hist.push_back(ref_pps);
        end
    end

    // Cycle-by-cycle comparison against the behavioural model
    int exp_val = 0;
    always @(negedge clk) begin
        if (rst_n && n > 0) begin
            bit exp_stb;
            bit exp_wrap;
            exp_stb  = ref_at(n-2) && !ref_at(n-3);
            exp_wrap = (n % 4 == 0) && ((n / 4) % SPAN == 0);
            if (exp_stb) exp_val = count_after(n-1);
            check(cap_stb == exp_stb, "R4 R5 strobe", int'(cap_stb), int'(exp_stb));
            check(int'(cap_val) == exp_val, "R1 R2 R4 R6 R7 value", int'(cap_val), exp_val);
            check(wrap_tick == exp_wrap, "R2 R3 wrap", int'(wrap_tick), int'(exp_wrap));
            if (cap_stb) caps.push_back(int'(cap_val));
        end
    end

    task automatic pulses(int period, int count, int width);
        for (int p = 0; p < count; p++) begin
            @(negedge clk); ref_pps = 1'b1;
            repeat (width) @(negedge clk);
            ref_pps = 1'b0;
            repeat (period - width - 1) @(negedge clk);
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic phase(string req, int period, int count, int width, int step);
        caps.delete();
        pulses(period, count, width);
        check(caps.size() == count, {req, " R5 capture count"}, caps.size(), count);
        for (int i = 1; i < caps.size(); i++)
            check(wrap_diff(caps[i-1], caps[i]) == step, req,
                  wrap_diff(caps[i-1], caps[i]), step);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                // R9: reset state
                check(cap_val == 8'd0, "R9 value", int'(cap_val), 0);
                check(cap_stb == 1'b0, "R9 strobe", int'(cap_stb), 0);
                check(wrap_tick == 1'b0, "R9 wrap", int'(wrap_tick), 0);
                rst_n = 1'b1;
                repeat (37) @(negedge clk);
                phase("R8 steady", 1000, 5, 3, 0);
                phase("R7 R8 fast", 1004, 5, 20, 1);
                phase("R8 slow", 996, 5, 1, -1);
                phase("R2 R8 large step", 1400, 6, 2, 100);
                done = 1;
            end
            begin
                while (cycles < WATCHDOG) @(posedge clk);
                if (!done) begin
                    errors++;
                    checks++;
                    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, WATCHDOG);
                end
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule